// File: doc/BRIEF.md
# Security-Banked Interrupt and Reset Control Register

This block is one memory-mapped control word for an interrupt controller that serves two security states. It decodes a simple register bus: a word offset, read and write strobes, 32-bit write data, combinational read data, and a secure attribute that comes with each access. Software uses it to choose how interrupt priorities are split into group and sub-priority, to configure three settings that only the secure state owns, and to request a system reset.

A write counts only when its upper half carries the unlock key. Each security state has its own copy of the priority-grouping value. The arbiter downstream receives a group-priority mask built from the non-secure copy. It also receives a strobe after every accepted write, so it can re-evaluate. A build-time parameter removes the security extension. In that build every access is treated as non-secure, there is a single grouping copy, and the fault-target bit reads as a constant one. Reads return data in the same cycle as the read strobe. Writes take effect at the next clock edge. The output pulses appear in the cycle after the write.

Top module: `sec_irq_rst_ctrl`

## Requirements
- R1: A write to the register offset is accepted only when write data bits 31:16 equal 16'h05FA. Any other key leaves all state unchanged and produces no output pulse.
- R2: A read of the register offset returns 16'hFA05 in bits 31:16 and the accessing state's grouping value in bits 10:8, in the same cycle as the read strobe. Bits 15, 12:11, 7:4 and 2:0 read as zero.
- R3: The 3-bit grouping value is written from data bits 10:8. An accepted write updates only the copy selected by the access's secure attribute (1 = secure).
- R4: Bit 3 (non-secure reset blocked), bit 13 (fault target) and bit 14 (secure priority boost) are all loaded from the write data by an accepted secure write. Non-secure writes never change them.
- R5: A secure read returns the stored bits 3, 13 and 14. A non-secure read returns stored bit 13 and reads bits 3 and 14 as zero.
- R6: An accepted write with data bit 2 set raises reset_req_o for exactly the one following cycle. No pulse is produced when the access is non-secure and the stored bit 3 is one.
- R7: With SEC_EXT = 0 the secure attribute is ignored, so all accesses act as non-secure. Bit 13 always reads as one.
- R8: group_mask_o equals all-ones shifted left by (non-secure grouping value + 1), truncated to MASK_W bits. A grouping value of 7 therefore gives an all-zero mask at the default width of 8.
- R9: Data bits 1:0 are not stored. An accepted write with either of them set raises misuse_o for the following cycle only and changes no other state.
- R10: Every accepted write raises prio_update_o for the following cycle. This includes the cycle in which reset_req_o is high.
- R11: After reset, both grouping copies and bits 3 and 14 are zero. Bit 13 is zero when SEC_EXT = 1 and one when SEC_EXT = 0. group_mask_o resets to all-ones except bit 0.
- R12: A read of any other offset returns zero, and a write to any other offset changes nothing and pulses nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word offset of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_secure | input | 1 | Access is from the secure state |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| reset_req_o | output | 1 | One-cycle system reset request |
| prio_update_o | output | 1 | One-cycle strobe to re-evaluate priorities |
| misuse_o | output | 1 | One-cycle flag when write data bits 1:0 are set |
| group_mask_o | output | MASK_W | Group-priority mask from the non-secure grouping value |

## Verification
The assertions assume that bus_rd and bus_wr are never high in the same cycle, and that the secure attribute is stable for the whole access. The bench keeps to this by issuing one access per clock, with every input driven from a single task between edges. The pulse assertions look back exactly one cycle to the triggering write. A stimulus that is held across several edges would therefore mean several writes, and the bench never holds one.

// File: rtl/sec_irq_rst_pkg.sv
package sec_irq_rst_pkg;
  localparam logic [15:0] WR_KEY = 16'h05FA;
  localparam logic [15:0] RD_KEY = 16'hFA05;
  localparam int GRP_W = 3;

  typedef struct packed {
    logic sec_boost;     // bit 14
    logic fault_tgt;     // bit 13
    logic rst_sec_only;  // bit 3
  } scfg_t;
endpackage

// File: rtl/sec_irq_rst_access.sv
module sec_irq_rst_access #(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] REG_OFF = '0,
  parameter bit SEC_EXT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_secure,
  input  logic [15:0]       key,
  input  logic              req_bit,
  input  logic [1:0]        low_bits,
  input  logic              rst_blocked,
  output logic              hit,
  output logic              eff_sec,
  output logic              wr_ok,
  output logic              req_q,
  output logic              upd_q,
  output logic              err_q
);
  import sec_irq_rst_pkg::*;

  assign hit = (bus_addr == REG_OFF);

  generate
    if (SEC_EXT) begin : g_sec
      assign eff_sec = bus_secure;
    end else begin : g_nosec
      logic unused_sec;
      assign unused_sec = bus_secure;
      assign eff_sec = 1'b0;
    end
  endgenerate

  assign wr_ok = bus_wr && hit && (key == WR_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      upd_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      req_q <= wr_ok && req_bit && (eff_sec || !rst_blocked);
      upd_q <= wr_ok;
      err_q <= wr_ok && (|low_bits);
    end
  end
endmodule

// File: rtl/sec_irq_rst_bank.sv
module sec_irq_rst_bank #(
  parameter bit SEC_EXT = 1'b1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                ld,
  input  logic                                sel_sec,
  input  logic [sec_irq_rst_pkg::GRP_W-1:0]   d,
  output logic [sec_irq_rst_pkg::GRP_W-1:0]   grp_ns,
  output logic [sec_irq_rst_pkg::GRP_W-1:0]   grp_sel
);
  import sec_irq_rst_pkg::*;
  localparam int NBANK = SEC_EXT ? 2 : 1;

  logic [GRP_W-1:0] grp_q [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) grp_q[b] <= '0;
      else if (ld && (sel_sec == (b == 1))) grp_q[b] <= d;
    end
  end

  assign grp_ns = grp_q[0];

  generate
    if (SEC_EXT) begin : g_two
      assign grp_sel = sel_sec ? grp_q[NBANK-1] : grp_q[0];
    end else begin : g_one
      assign grp_sel = grp_q[0];
    end
  endgenerate
endmodule

// File: rtl/sec_irq_rst_cfg.sv
module sec_irq_rst_cfg #(
  parameter bit SEC_EXT = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld,
  input  sec_irq_rst_pkg::scfg_t  d,
  output sec_irq_rst_pkg::scfg_t  q
);
  import sec_irq_rst_pkg::*;

  generate
    if (SEC_EXT) begin : g_sec
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (ld) q <= d;
      end
    end else begin : g_fixed
      logic unused_cfg;
      assign unused_cfg = ^{clk, rst_n, ld, d};
      assign q = '{sec_boost: 1'b0, fault_tgt: 1'b1, rst_sec_only: 1'b0};
    end
  endgenerate
endmodule

// File: rtl/sec_irq_rst_mask.sv
module sec_irq_rst_mask #(
  parameter int MASK_W = 8
) (
  input  logic [sec_irq_rst_pkg::GRP_W-1:0] grp,
  output logic [MASK_W-1:0]                 mask
);
  for (genvar i = 0; i < MASK_W; i++) begin : g_bit
    assign mask[i] = (i > int'(grp));
  end
endmodule

// File: rtl/sec_irq_rst_ctrl.sv
module sec_irq_rst_ctrl #(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] REG_OFF = 10'h343,
  parameter bit SEC_EXT = 1'b1,
  parameter int MASK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_secure,
  output logic [31:0]       bus_rdata,
  output logic              reset_req_o,
  output logic              prio_update_o,
  output logic              misuse_o,
  output logic [MASK_W-1:0] group_mask_o
);
  import sec_irq_rst_pkg::*;

  logic             hit, eff_sec, wr_ok;
  logic [GRP_W-1:0] grp_ns, grp_sel;
  scfg_t            scfg_q, scfg_d;
  logic [31:0]      rd_val;
  logic             unused_wdata;

  assign unused_wdata = ^{bus_wdata[15], bus_wdata[12:11], bus_wdata[7:4]};

  sec_irq_rst_access #(.ADDR_W(ADDR_W), .REG_OFF(REG_OFF), .SEC_EXT(SEC_EXT)) u_access (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_secure(bus_secure), .key(bus_wdata[31:16]), .req_bit(bus_wdata[2]),
    .low_bits(bus_wdata[1:0]), .rst_blocked(scfg_q.rst_sec_only),
    .hit(hit), .eff_sec(eff_sec), .wr_ok(wr_ok),
    .req_q(reset_req_o), .upd_q(prio_update_o), .err_q(misuse_o)
  );

  sec_irq_rst_bank #(.SEC_EXT(SEC_EXT)) u_bank (
    .clk(clk), .rst_n(rst_n), .ld(wr_ok), .sel_sec(eff_sec),
    .d(bus_wdata[10:8]), .grp_ns(grp_ns), .grp_sel(grp_sel)
  );

  assign scfg_d = '{sec_boost: bus_wdata[14], fault_tgt: bus_wdata[13],
                    rst_sec_only: bus_wdata[3]};

  sec_irq_rst_cfg #(.SEC_EXT(SEC_EXT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .ld(wr_ok && eff_sec), .d(scfg_d), .q(scfg_q)
  );

  sec_irq_rst_mask #(.MASK_W(MASK_W)) u_mask (
    .grp(grp_ns), .mask(group_mask_o)
  );

  assign rd_val = {RD_KEY, 1'b0, scfg_q.sec_boost & eff_sec, scfg_q.fault_tgt,
                   2'b00, grp_sel, 4'b0000, scfg_q.rst_sec_only & eff_sec, 3'b000};

  assign bus_rdata = (bus_rd && hit) ? rd_val : 32'h0;
endmodule

// File: rtl/sec_irq_rst_ctrl_chk.sv
module sec_irq_rst_ctrl_chk #(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] REG_OFF = 10'h343,
  parameter bit SEC_EXT = 1'b1,
  parameter int MASK_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic                   bus_rd,
  input logic                   bus_wr,
  input logic [31:0]            bus_wdata,
  input logic                   bus_secure,
  input logic [31:0]            bus_rdata,
  input logic                   reset_req_o,
  input logic                   prio_update_o,
  input logic                   misuse_o,
  input logic [MASK_W-1:0]      group_mask_o,
  input sec_irq_rst_pkg::scfg_t scfg_q
);
  logic good_wr;
  assign good_wr = bus_wr && (bus_addr == REG_OFF) && (bus_wdata[31:16] == 16'h05FA);

  a_r1_bad_key_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_wdata[31:16] != 16'h05FA) |=> (!prio_update_o && !reset_req_o));

  a_r2_read_key: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == REG_OFF) |-> (bus_rdata[31:16] == 16'hFA05));

  a_r4_ns_write_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_secure) |=> $stable(scfg_q));

  a_r5_ns_hides_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == REG_OFF && !bus_secure) |-> (!bus_rdata[3] && !bus_rdata[14]));

  a_r6_req_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |-> $past(good_wr && bus_wdata[2]));

  a_r8_mask_moves_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(good_wr) |-> $stable(group_mask_o));

  a_r9_misuse_needs_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    misuse_o |-> $past(good_wr && bus_wdata[1:0] != 2'b00));

  a_r10_req_with_update: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |-> prio_update_o);

  a_r12_other_offset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr != REG_OFF) |-> (bus_rdata == 32'h0));

  generate
    if (!SEC_EXT) begin : g_nosec
      a_r7_target_bit_one: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == REG_OFF) |-> bus_rdata[13]);
    end
  endgenerate
endmodule

bind sec_irq_rst_ctrl sec_irq_rst_ctrl_chk #(
  .ADDR_W(ADDR_W), .REG_OFF(REG_OFF), .SEC_EXT(SEC_EXT), .MASK_W(MASK_W)
) u_chk (.*);

// File: tb/sec_irq_rst_ctrl_bench.sv
module sec_irq_rst_ctrl_bench;
  localparam logic [9:0] OFF = 10'h343;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0, bus_secure = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata [2];
  logic req [2], upd [2], err [2];
  logic [7:0] mask [2];

  int checks = 0, errors = 0;
  bit done = 0;

  // model state per instance: 0 = with security, 1 = without
  int mgrp [2][2];
  bit mc3 [2], mc13 [2], mc14 [2];
  bit e_req [2], e_upd [2], e_err [2];

  always #2 clk = ~clk;

  sec_irq_rst_ctrl u_sec_irq_rst_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_secure(bus_secure), .bus_rdata(rdata[0]),
    .reset_req_o(req[0]), .prio_update_o(upd[0]), .misuse_o(err[0]), .group_mask_o(mask[0]));

  sec_irq_rst_ctrl #(.SEC_EXT(1'b0)) u_sec_irq_rst_ctrl_nosec (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_secure(bus_secure), .bus_rdata(rdata[1]),
    .reset_req_o(req[1]), .prio_update_o(upd[1]), .misuse_o(err[1]), .group_mask_o(mask[1]));

  task automatic check(string tag, int d, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s dut%0d: actual %h expected %h", tag, d, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(int d);
    bit s = (d == 0) ? bus_secure : 1'b0;
    logic [31:0] v;
    if (!(bus_rd && bus_addr == OFF)) return 32'h0;
    v = 32'hFA05_0000 | (32'(mgrp[d][s]) << 8);
    if (mc13[d]) v[13] = 1'b1;
    if (s && mc3[d]) v[3] = 1'b1;
    if (s && mc14[d]) v[14] = 1'b1;
    return v;
  endfunction

  function automatic logic [7:0] exp_mask(int d);
    logic [7:0] m;
    for (int i = 0; i < 8; i++) m[i] = (i > mgrp[d][0]);
    return m;
  endfunction

  task automatic model_step();
    for (int d = 0; d < 2; d++) begin
      bit s = (d == 0) ? bus_secure : 1'b0;
      bit acc = bus_wr && bus_addr == OFF && bus_wdata[31:16] == 16'h05FA;
      e_req[d] = acc && bus_wdata[2] && (s || !mc3[d]);
      e_upd[d] = acc;
      e_err[d] = acc && (bus_wdata[1:0] != 2'b00);
      if (acc) begin
        mgrp[d][s] = int'(bus_wdata[10:8]);
        if (s) begin
          mc3[d] = bus_wdata[3]; mc13[d] = bus_wdata[13]; mc14[d] = bus_wdata[14];
        end
      end
    end
  endtask

  task automatic op(string tag, bit rd, bit wr, logic [9:0] a, logic [31:0] wd, bit sec);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd; bus_secure = sec;
    #1;
    for (int d = 0; d < 2; d++) check({tag, " rdata"}, d, rdata[d], exp_read(d));
    @(posedge clk);
    model_step();
    @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      check({tag, " R6 reset_req"}, d, 32'(req[d]), 32'(e_req[d]));
      check({tag, " R10 prio_update"}, d, 32'(upd[d]), 32'(e_upd[d]));
      check({tag, " R9 misuse"}, d, 32'(err[d]), 32'(e_err[d]));
      check({tag, " R8 mask"}, d, 32'(mask[d]), 32'(exp_mask(d)));
    end
  endtask

  initial begin
    for (int d = 0; d < 2; d++) begin
      mgrp[d][0] = 0; mgrp[d][1] = 0; mc3[d] = 0; mc14[d] = 0; mc13[d] = (d == 1);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    for (int d = 0; d < 2; d++) check("R11 reset mask", d, 32'(mask[d]), 32'h0000_00FE);
    op("R11 R2 reset read secure", 1, 0, OFF, 0, 1);
    op("R11 R5 reset read nonsecure", 1, 0, OFF, 0, 0);
    // R3 R4 secure write of group 5 and all secure-only bits
    op("R3 R4 secure write", 0, 1, OFF, 32'h05FA_6508, 1);
    op("R5 R7 secure read", 1, 0, OFF, 0, 1);
    op("R5 R7 nonsecure read", 1, 0, OFF, 0, 0);
    // R3 R4 nonsecure write: group 2, secure-only bits must not change
    op("R4 nonsecure write", 0, 1, OFF, 32'h05FA_0208, 0);
    op("R3 R5 nonsecure read", 1, 0, OFF, 0, 0);
    op("R4 secure read after ns write", 1, 0, OFF, 0, 1);
    // R1 bad key
    op("R1 bad key write", 0, 1, OFF, 32'h1234_0704, 0);
    op("R1 bad key secure", 0, 1, OFF, 32'h05FB_0004, 1);
    op("R1 read after bad key", 1, 0, OFF, 0, 0);
    // R6 nonsecure request blocked while bit 3 stored
    op("R6 ns req blocked", 0, 1, OFF, 32'h05FA_0204, 0);
    op("R6 secure req", 0, 1, OFF, 32'h05FA_650C, 1);
    op("R6 secure req again", 0, 1, OFF, 32'h05FA_650C, 1);
    op("R6 idle after req", 0, 0, OFF, 0, 0);
    // clear bit 3, then nonsecure request goes through, group 7 -> R8 mask zero
    op("R4 secure clear bit3", 0, 1, OFF, 32'h05FA_2500, 1);
    op("R6 ns req allowed", 0, 1, OFF, 32'h05FA_0704, 0);
    op("R8 read group 7", 1, 0, OFF, 0, 0);
    // R9 low bits
    op("R9 low bits ns", 0, 1, OFF, 32'h05FA_0303, 0);
    op("R9 low bits secure", 0, 1, OFF, 32'h05FA_4501, 1);
    op("R9 read after low bits", 1, 0, OFF, 0, 1);
    // R12 other offsets
    op("R12 write other offset", 0, 1, OFF + 10'd1, 32'h05FA_6004, 1);
    op("R12 read other offset", 1, 0, OFF - 10'd1, 0, 1);
    op("R12 read after other write", 1, 0, OFF, 0, 1);
    op("R12 read after other write ns", 1, 0, OFF, 0, 0);
    op("R8 group 0 mask", 0, 1, OFF, 32'h05FA_0000, 0);
    op("final idle", 0, 0, OFF, 0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule